// File: doc/BRIEF.md
# Directory-Coherent Cache Block Controller

This block keeps one frame of a private cache coherent in a multiprocessor where a home directory, not a shared bus, decides who holds a block. It receives processor reads and writes for one word of a multi-word block. It answers hits at once. On a miss it holds the processor and asks the home directory for the block over a point-to-point request channel. Directory commands that invalidate the frame or recall its contents arrive on a separate input. The block applies them to the frame's coherence state and returns dirty data with a write-back message.

The frame holds one block address at a time. A miss to another block replaces the resident one, and a dirty victim is written back before the new request goes out. The processor keeps its request asserted until it sees the completion strobe. Directory messages are taken one per cycle, in order, and are never back-pressured.

Top module: `dirCohBlock`

## Requirements
- R1: After reset the frame is Invalid with an empty block, no outgoing message is offered and no protocol error is flagged.
- R2: A read in Invalid, or to a block other than the resident one while not dirty, emits a read miss (type code 0) for the requested block address. When the data reply (directory type code 3) arrives, the frame becomes Shared. The retried read then returns the selected word of the reply payload.
- R3: A write while Invalid, or while Shared (same or other block), emits a write miss (type code 1). After the reply the frame is Exclusive, and the write merges its word into the returned block while leaving the other words as replied.
- R4: An invalidate (directory type code 0) whose block address matches a Shared frame makes it Invalid in any phase, so the next read misses. An invalidate that does not match, or that finds the frame Exclusive or Invalid, has no effect.
- R5: A fetch (directory type code 1) matching an Exclusive frame emits a write-back (type code 2) carrying the resident block address and the whole block payload. The frame is left Shared: reads still hit and writes miss.
- R6: A fetch-and-invalidate (directory type code 2) matching an Exclusive frame emits the same write-back and leaves the frame Invalid.
- R7: A read or write to another block while Exclusive first emits a write-back of the victim (old address, old payload). Only after that message is accepted does it emit the read or write miss for the new block.
- R8: Read hits in Shared or Exclusive and write hits in Exclusive assert the completion strobe in the same cycle with no stall and no message. A missing request keeps the stall output high until it completes.
- R9: An offered message is retired only in a cycle with both valid and ready high. While ready is low, valid, type, address and payload hold.
- R10: A data reply arriving when no miss is waiting raises the protocol error output for that cycle and changes neither state nor payload.
- R11: A directory message present in the same cycle as a processor request is acted on first, and the request is not completed in that cycle.
- R12: The processor address splits into a word offset (low bits) and a block address (high bits). Every message carries the block address and the fixed processor identifier, and misses carry a zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReqValid | input | 1 | Processor request present, held until completion |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Word address: block address above, word offset below |
| cpuWrData | input | WORD_W | Write word |
| cpuDone | output | 1 | Request completes this cycle |
| cpuStall | output | 1 | Request present and not completing |
| cpuRdData | output | WORD_W | Read word, valid with cpuDone |
| dirMsgValid | input | 1 | Directory message present |
| dirMsgType | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| dirMsgAddr | input | ADDR_W-log2(WORDS) | Block address of the directory message |
| dirMsgData | input | WORDS*WORD_W | Block payload of a data reply |
| outMsgValid | output | 1 | Outgoing message offered |
| outMsgReady | input | 1 | Interconnect accepts the offered message |
| outMsgType | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| outMsgProc | output | PID_W | Identifier of this processor |
| outMsgAddr | output | ADDR_W-log2(WORDS) | Block address of the message |
| outMsgData | output | WORDS*WORD_W | Block payload (write-back only) |
| protoErr | output | 1 | Data reply received with no miss waiting |

## Verification
The bench builds the block with its defaults: a 12-bit word address, four 16-bit words per block and processor identifier 3. Four words per block let the merge of a write land in a middle word, so a wrong offset or a lost neighbour word shows up in a later write-back payload. A non-zero identifier exposes a dropped identifier field. Stalling the ready input for several cycles during a victim write-back shows the hold rule and the write-back-before-miss ordering together. An invalidate injected while a write upgrade waits for its reply covers the case where an invalidate arrives during a miss.

// File: rtl/cohBlockPkg.sv
package cohBlockPkg;

  typedef enum logic [1:0] {
    COH_INV = 2'd0,
    COH_SHR = 2'd1,
    COH_EXC = 2'd2
  } cohState_e;

  typedef enum logic [1:0] {
    DIR_INVAL       = 2'd0,
    DIR_FETCH       = 2'd1,
    DIR_FETCH_INVAL = 2'd2,
    DIR_REPLY       = 2'd3
  } dirMsg_e;

  typedef enum logic [1:0] {
    OUT_RD_MISS    = 2'd0,
    OUT_WR_MISS    = 2'd1,
    OUT_WRITE_BACK = 2'd2
  } outMsg_e;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_VICTIM_WB = 3'd1,
    PH_FETCH_WB = 3'd2,
    PH_REQ      = 3'd3,
    PH_WAIT     = 3'd4
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTag;
    logic loadBlock;
    logic writeWord;
    logic sendBlock;
  } dpStrobe_t;

endpackage

// File: rtl/cohBlockData.sv
module cohBlockData
  import cohBlockPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int WORDS  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strobe,
  input  logic [ADDR_W-1:0]                 cpuReqAddr,
  input  logic [WORD_W-1:0]                 cpuWrData,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]   dirMsgAddr,
  input  logic [WORDS*WORD_W-1:0]           dirMsgData,
  output logic                              cpuTagHit,
  output logic                              dirTagHit,
  output logic [WORD_W-1:0]                 rdWord,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   msgAddr,
  output logic [WORDS*WORD_W-1:0]           msgData
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int BA_W  = ADDR_W - OFF_W;
  localparam int BLK_W = WORDS * WORD_W;

  logic [BA_W-1:0]   tagQ;
  logic [BLK_W-1:0]  blockQ;
  logic [BLK_W-1:0]  blockD;
  logic [OFF_W-1:0]  cpuOff;
  logic [BA_W-1:0]   cpuBlk;
  logic [WORD_W-1:0] wordSel [WORDS];

  assign cpuOff = cpuReqAddr[OFF_W-1:0];
  assign cpuBlk = cpuReqAddr[ADDR_W-1:OFF_W];

  assign cpuTagHit = (cpuBlk == tagQ);
  assign dirTagHit = (dirMsgAddr == tagQ);

  // per-word fill / merge and read select
  for (genvar w = 0; w < WORDS; w++) begin : gWord
    assign wordSel[w] = blockQ[w*WORD_W +: WORD_W];
    assign blockD[w*WORD_W +: WORD_W] =
        strobe.loadBlock                               ? dirMsgData[w*WORD_W +: WORD_W] :
        (strobe.writeWord && cpuOff == OFF_W'(w))      ? cpuWrData :
                                                         blockQ[w*WORD_W +: WORD_W];
  end

  assign rdWord  = wordSel[cpuOff];
  assign msgAddr = tagQ;
  assign msgData = strobe.sendBlock ? blockQ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ   <= '0;
      blockQ <= '0;
    end else begin
      if (strobe.loadTag) tagQ <= cpuBlk;
      blockQ <= blockD;
    end
  end

  // a fill never coincides with a tag change
  AST_FILL_NO_RETAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBlock |=> $stable(tagQ)) else $error("fill moved tag"); // R2

endmodule

// File: rtl/cohBlockCtrl.sv
module cohBlockCtrl
  import cohBlockPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReqValid,
  input  logic       cpuReqWrite,
  input  logic       cpuTagHit,
  input  logic       dirMsgValid,
  input  logic [1:0] dirMsgType,
  input  logic       dirTagHit,
  input  logic       outMsgReady,
  output dpStrobe_t  strobe,
  output logic       cpuDone,
  output logic       outValid,
  output logic [1:0] outType,
  output logic       protoErr
);

  cohState_e cohQ, cohD;
  phase_e    phaseQ, phaseD;
  logic      pendWrQ, pendWrD;
  dirMsg_e   dirKind;
  logic      isReply;
  logic      isRecall;
  logic      cpuHit;

  assign dirKind  = dirMsg_e'(dirMsgType);
  assign isReply  = dirMsgValid && (dirKind == DIR_REPLY);
  assign isRecall = dirMsgValid && dirTagHit && (cohQ == COH_EXC) &&
                    (dirKind == DIR_FETCH || dirKind == DIR_FETCH_INVAL);
  assign cpuHit   = (cohQ != COH_INV) && cpuTagHit &&
                    (!cpuReqWrite || cohQ == COH_EXC);

  always_comb begin
    cohD     = cohQ;
    phaseD   = phaseQ;
    pendWrD  = pendWrQ;
    strobe   = '0;
    cpuDone  = 1'b0;
    outValid = 1'b0;
    outType  = OUT_RD_MISS;
    protoErr = 1'b0;

    // invalidation of a shared copy is honoured in every phase
    if (dirMsgValid && dirKind == DIR_INVAL && dirTagHit && cohQ == COH_SHR)
      cohD = COH_INV;

    if (isReply && phaseQ != PH_WAIT)
      protoErr = 1'b1;

    unique case (phaseQ)
      PH_IDLE: begin
        if (isRecall) begin
          cohD   = (dirKind == DIR_FETCH) ? COH_SHR : COH_INV;
          phaseD = PH_FETCH_WB;
        end else if (!dirMsgValid && cpuReqValid) begin
          if (cpuHit) begin
            cpuDone          = 1'b1;
            strobe.writeWord = cpuReqWrite;
          end else if (cohQ == COH_EXC && !cpuTagHit) begin
            phaseD = PH_VICTIM_WB;
          end else begin
            strobe.loadTag = 1'b1;
            pendWrD        = cpuReqWrite;
            cohD           = (cpuTagHit && cohQ == COH_SHR && cpuReqWrite) ? COH_SHR : COH_INV;
            phaseD         = PH_REQ;
          end
        end
      end
      PH_VICTIM_WB: begin
        outValid         = 1'b1;
        outType          = OUT_WRITE_BACK;
        strobe.sendBlock = 1'b1;
        if (outMsgReady) begin
          cohD           = COH_INV;
          strobe.loadTag = 1'b1;
          pendWrD        = cpuReqWrite;
          phaseD         = PH_REQ;
        end
      end
      PH_FETCH_WB: begin
        outValid         = 1'b1;
        outType          = OUT_WRITE_BACK;
        strobe.sendBlock = 1'b1;
        if (outMsgReady) phaseD = PH_IDLE;
      end
      PH_REQ: begin
        outValid = 1'b1;
        outType  = pendWrQ ? OUT_WR_MISS : OUT_RD_MISS;
        if (outMsgReady) phaseD = PH_WAIT;
      end
      PH_WAIT: begin
        if (isReply) begin
          strobe.loadBlock = 1'b1;
          cohD             = pendWrQ ? COH_EXC : COH_SHR;
          phaseD           = PH_IDLE;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cohQ    <= COH_INV;
      phaseQ  <= PH_IDLE;
      pendWrQ <= 1'b0;
    end else begin
      cohQ    <= cohD;
      phaseQ  <= phaseD;
      pendWrQ <= pendWrD;
    end
  end

  AST_READ_FILL_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_WAIT && isReply && !pendWrQ) |=> cohQ == COH_SHR) else $error("read fill"); // R2
  AST_WRITE_FILL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_WAIT && isReply && pendWrQ) |=> cohQ == COH_EXC) else $error("write fill"); // R3
  AST_VICTIM_BEFORE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_VICTIM_WB && outMsgReady) |=> (outValid && outType != OUT_WRITE_BACK)) else $error("order"); // R7
  AST_WRITE_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuReqWrite) |-> cohQ == COH_EXC) else $error("write hit"); // R8
  AST_OUT_HOLD_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outMsgReady) |=> (outValid && $stable(outType))) else $error("hold"); // R9
  AST_ERR_NEEDS_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (dirMsgValid && dirMsgType == 2'd3 && $stable(cohQ))) else $error("err"); // R10
  AST_DIR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    dirMsgValid |-> !cpuDone) else $error("priority"); // R11

endmodule

// File: rtl/dirCohBlock.sv
module dirCohBlock
  import cohBlockPkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4,
  parameter int PID_W   = 2,
  parameter int PROC_ID = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cpuReqValid,
  input  logic                              cpuReqWrite,
  input  logic [ADDR_W-1:0]                 cpuReqAddr,
  input  logic [WORD_W-1:0]                 cpuWrData,
  output logic                              cpuDone,
  output logic                              cpuStall,
  output logic [WORD_W-1:0]                 cpuRdData,
  input  logic                              dirMsgValid,
  input  logic [1:0]                        dirMsgType,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]   dirMsgAddr,
  input  logic [WORDS*WORD_W-1:0]           dirMsgData,
  output logic                              outMsgValid,
  input  logic                              outMsgReady,
  output logic [1:0]                        outMsgType,
  output logic [PID_W-1:0]                  outMsgProc,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   outMsgAddr,
  output logic [WORDS*WORD_W-1:0]           outMsgData,
  output logic                              protoErr
);

  dpStrobe_t strobe;
  logic      cpuTagHit;
  logic      dirTagHit;

  cohBlockCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReqValid (cpuReqValid),
    .cpuReqWrite (cpuReqWrite),
    .cpuTagHit   (cpuTagHit),
    .dirMsgValid (dirMsgValid),
    .dirMsgType  (dirMsgType),
    .dirTagHit   (dirTagHit),
    .outMsgReady (outMsgReady),
    .strobe      (strobe),
    .cpuDone     (cpuDone),
    .outValid    (outMsgValid),
    .outType     (outMsgType),
    .protoErr    (protoErr)
  );

  cohBlockData #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .WORDS  (WORDS)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuReqAddr (cpuReqAddr),
    .cpuWrData  (cpuWrData),
    .dirMsgAddr (dirMsgAddr),
    .dirMsgData (dirMsgData),
    .cpuTagHit  (cpuTagHit),
    .dirTagHit  (dirTagHit),
    .rdWord     (cpuRdData),
    .msgAddr    (outMsgAddr),
    .msgData    (outMsgData)
  );

  assign cpuStall   = cpuReqValid && !cpuDone;
  assign outMsgProc = PID_W'(PROC_ID);

  AST_OUT_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (outMsgValid && !outMsgReady) |=> ($stable(outMsgAddr) && $stable(outMsgData))) else $error("fields"); // R9
  AST_STALL_WHILE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && outMsgValid) |-> cpuStall) else $error("stall"); // R8
  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outMsgValid && outMsgType != 2'd2) |-> outMsgData == '0) else $error("miss data"); // R12

endmodule

// File: tb/dirCohBlock_tb_top.sv
`timescale 1ns/1ps
module dirCohBlock_tb_top;

  localparam int ADDR_W = 12;
  localparam int WORD_W = 16;
  localparam int WORDS  = 4;
  localparam int BA_W   = 10;
  localparam int BLK_W  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqV = 1'b0, reqW = 1'b0;
  logic [ADDR_W-1:0] reqA = '0;
  logic [WORD_W-1:0] wrD = '0;
  logic dV = 1'b0;
  logic [1:0] dT = '0;
  logic [BA_W-1:0] dA = '0;
  logic [BLK_W-1:0] dD = '0;
  logic rdy = 1'b1;

  logic cpuDone, cpuStall, outMsgValid, protoErr;
  logic [WORD_W-1:0] cpuRdData;
  logic [1:0] outMsgType, outMsgProc;
  logic [BA_W-1:0] outMsgAddr;
  logic [BLK_W-1:0] outMsgData;

  always #4 clk = ~clk;

  dirCohBlock dut_i (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(reqV), .cpuReqWrite(reqW), .cpuReqAddr(reqA), .cpuWrData(wrD),
    .cpuDone(cpuDone), .cpuStall(cpuStall), .cpuRdData(cpuRdData),
    .dirMsgValid(dV), .dirMsgType(dT), .dirMsgAddr(dA), .dirMsgData(dD),
    .outMsgValid(outMsgValid), .outMsgReady(rdy), .outMsgType(outMsgType),
    .outMsgProc(outMsgProc), .outMsgAddr(outMsgAddr), .outMsgData(outMsgData),
    .protoErr(protoErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  // behavioural model: coherence 0 I, 1 S, 2 E; busy 0 none,1 victim,2 recall,3 request,4 waiting
  int mCoh = 0, mTag = 0, mBusy = 0;
  bit mPw = 0;
  logic [BLK_W-1:0] mBlk = '0;
  int nCoh, nTag, nBusy;
  bit nPw;
  logic [BLK_W-1:0] nBlk;
  bit eDone, eOutV, eErr;
  int eType;
  logic [BLK_W-1:0] eData;
  logic [WORD_W-1:0] eRd;

  // observations
  int seenT[$];
  int seenA[$];
  logic [BLK_W-1:0] seenD[$];
  bit sawDone, sawErr, doneNow;
  logic [WORD_W-1:0] lastRd;
  int holdCnt = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelEval();
    int cba, off;
    bit match, dmatch, hit;
    cba = int'(reqA) >> 2;
    off = int'(reqA) & 3;
    match  = (cba == mTag);
    dmatch = (int'(dA) == mTag);
    nCoh = mCoh; nTag = mTag; nBusy = mBusy; nPw = mPw; nBlk = mBlk;
    eDone = 0; eOutV = 0; eErr = 0; eType = 0; eData = '0;
    eRd = mBlk[off*16 +: 16];
    if (dV && dT == 2'd0 && dmatch && mCoh == 1) nCoh = 0;
    if (dV && dT == 2'd3 && mBusy != 4) eErr = 1;
    hit = (mCoh != 0) && match && (!reqW || mCoh == 2);
    if (mBusy == 0) begin
      if (dV && (dT == 2'd1 || dT == 2'd2) && dmatch && mCoh == 2) begin
        nCoh = (dT == 2'd1) ? 1 : 0;
        nBusy = 2;
      end else if (!dV && reqV) begin
        if (hit) begin
          eDone = 1;
          if (reqW) nBlk[off*16 +: 16] = wrD;
        end else if (mCoh == 2 && !match) begin
          nBusy = 1;
        end else begin
          nCoh = (match && mCoh == 1 && reqW) ? 1 : 0;
          nTag = cba; nPw = reqW; nBusy = 3;
        end
      end
    end else if (mBusy == 1 || mBusy == 2) begin
      eOutV = 1; eType = 2; eData = mBlk;
      if (rdy) begin
        if (mBusy == 1) begin nCoh = 0; nTag = cba; nPw = reqW; nBusy = 3; end
        else nBusy = 0;
      end
    end else if (mBusy == 3) begin
      eOutV = 1; eType = mPw ? 1 : 0;
      if (rdy) nBusy = 4;
    end else begin
      if (dV && dT == 2'd3) begin
        nBlk = dD; nCoh = mPw ? 2 : 1; nBusy = 0;
      end
    end
  endtask

  task automatic tick();
    #1;
    modelEval();
    check("R8 done", 64'(cpuDone), 64'(eDone));
    check("R8 stall", 64'(cpuStall), 64'(reqV && !eDone));
    if (eDone && !reqW) check("R2 read word", 64'(cpuRdData), 64'(eRd));
    check("R9 out valid", 64'(outMsgValid), 64'(eOutV));
    if (eOutV) begin
      check("R12 out type", 64'(outMsgType), 64'(eType));
      check("R12 out proc", 64'(outMsgProc), 64'd3);
      check("R7 out addr", 64'(outMsgAddr), 64'(mTag));
      check("R5 out data", outMsgData, eData);
    end
    check("R10 proto err", 64'(protoErr), 64'(eErr));
    doneNow = cpuDone;
    if (cpuDone) begin sawDone = 1; lastRd = cpuRdData; end
    if (protoErr) sawErr = 1;
    if (outMsgValid && rdy) begin
      seenT.push_back(int'(outMsgType));
      seenA.push_back(int'(outMsgAddr));
      seenD.push_back(outMsgData);
      holdCnt = 0;
    end else if (outMsgValid) holdCnt++;
    @(posedge clk);
    mCoh = nCoh; mTag = nTag; mBusy = nBusy; mPw = nPw; mBlk = nBlk;
    @(negedge clk);
  endtask

  task automatic clearSeen();
    seenT.delete(); seenA.delete(); seenD.delete();
  endtask

  task automatic access(input bit w, input logic [11:0] a, input logic [15:0] d,
                        input int delay, input logic [63:0] reply, input bit invFirst);
    bit invSent = 0;
    reqV = 1; reqW = w; reqA = a; wrD = d; sawDone = 0; holdCnt = 0;
    for (int c = 0; c < 60 && !sawDone; c++) begin
      dV = 0; dT = 0; dA = BA_W'(mTag); dD = '0;
      if (mBusy == 4) begin
        if (invFirst && !invSent) begin dV = 1; dT = 2'd0; invSent = 1; end
        else begin dV = 1; dT = 2'd3; dD = reply; end
      end
      rdy = (holdCnt >= delay);
      tick();
    end
    dV = 0; reqV = 0; rdy = 1;
    check("R8 access completes", 64'(sawDone), 64'd1);
  endtask

  task automatic dirMsg(input logic [1:0] t, input logic [9:0] ba, input logic [63:0] d);
    dV = 1; dT = t; dA = ba; dD = d; rdy = 1;
    tick();
    dV = 0; dD = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL R8 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: quiet after reset
    sawErr = 0;
    idle(2);
    check("R1 no message", 64'(outMsgValid), 64'd0);
    check("R1 no error", 64'(sawErr), 64'd0);

    // R2: read miss then shared fill
    clearSeen();
    access(0, 12'h041, 16'h0, 0, 64'h4444_3333_2222_1111, 0);
    check("R1 R2 read miss count", 64'(seenT.size()), 64'd1);
    check("R2 read miss type", 64'(seenT[0]), 64'd0);
    check("R2 read miss addr", 64'(seenA[0]), 64'h010);
    check("R2 read word", 64'(lastRd), 64'h2222);

    // R8: read hit, no message
    clearSeen();
    access(0, 12'h043, 16'h0, 0, 64'h0, 0);
    check("R8 hit word", 64'(lastRd), 64'h4444);
    check("R8 hit silent", 64'(seenT.size()), 64'd0);

    // R3 R4: write upgrade with an invalidate arriving while waiting
    clearSeen();
    access(1, 12'h040, 16'hAAAA, 0, 64'h8888_7777_6666_5555, 1);
    check("R3 write miss type", 64'(seenT[0]), 64'd1);
    access(0, 12'h040, 16'h0, 0, 64'h0, 0);
    check("R3 merged word", 64'(lastRd), 64'hAAAA);
    access(0, 12'h041, 16'h0, 0, 64'h0, 0);
    check("R3 neighbour word", 64'(lastRd), 64'h6666);

    // R8: write hit in exclusive
    clearSeen();
    access(1, 12'h041, 16'hBBBB, 0, 64'h0, 0);
    check("R8 write hit silent", 64'(seenT.size()), 64'd0);

    // R5: fetch returns data, frame shared
    clearSeen();
    dirMsg(2'd1, 10'h010, 64'h0);
    idle(2);
    check("R5 wb type", 64'(seenT[0]), 64'd2);
    check("R5 wb data", seenD[0], 64'h8888_7777_BBBB_AAAA);
    access(0, 12'h041, 16'h0, 0, 64'h0, 0);
    check("R5 read still hits", 64'(lastRd), 64'hBBBB);
    check("R5 no extra message", 64'(seenT.size()), 64'd1);
    clearSeen();
    access(1, 12'h042, 16'hCCCC, 0, 64'h1234_5678_9ABC_DEF0, 0);
    check("R5 write misses", 64'(seenT[0]), 64'd1);

    // R6: fetch-and-invalidate
    clearSeen();
    dirMsg(2'd2, 10'h010, 64'h0);
    idle(2);
    check("R6 wb data", seenD[0], 64'h1234_CCCC_9ABC_DEF0);
    access(0, 12'h041, 16'h0, 0, 64'h1111_2222_3333_4444, 0);
    check("R6 read misses after", 64'(seenT[1]), 64'd0);
    check("R6 refill word", 64'(lastRd), 64'h3333);

    access(1, 12'h041, 16'h5555, 0, 64'h1111_2222_3333_4444, 0);

    // R7 R9: victim write-back with slow ready, then read miss
    clearSeen();
    access(0, 12'h0A2, 16'h0, 3, 64'hFEED_CAFE_BEEF_F00D, 0);
    check("R7 first is wb", 64'(seenT[0]), 64'd2);
    check("R7 victim addr", 64'(seenA[0]), 64'h010);
    check("R9 victim data", seenD[0], 64'h1111_2222_5555_4444);
    check("R7 then read miss", 64'(seenT[1]), 64'd0);
    check("R12 new block addr", 64'(seenA[1]), 64'h028);
    check("R2 new word", 64'(lastRd), 64'hCAFE);

    // R7: write to another block while exclusive
    access(1, 12'h0A0, 16'h7777, 0, 64'h0, 0);
    clearSeen();
    access(1, 12'h041, 16'h1357, 0, 64'h0, 0);
    check("R7 wb before write miss", 64'(seenT[0]), 64'd2);
    check("R7 wb payload", seenD[0], 64'h0000_0000_0000_7777);
    check("R7 write miss follows", 64'(seenT[1]), 64'd1);

    // R10: unexpected reply
    sawErr = 0;
    dirMsg(2'd3, 10'h010, 64'hDEAD_DEAD_DEAD_DEAD);
    check("R10 error seen", 64'(sawErr), 64'd1);
    clearSeen();
    access(0, 12'h041, 16'h0, 0, 64'h0, 0);
    check("R10 payload untouched", 64'(lastRd), 64'h1357);

    // R4: invalidates that must not act
    dirMsg(2'd0, 10'h028, 64'h0);
    dirMsg(2'd0, 10'h010, 64'h0);
    access(0, 12'h041, 16'h0, 0, 64'h0, 0);
    check("R4 ignored invalidate", 64'(seenT.size()), 64'd0);

    // R11: directory message wins the cycle
    reqV = 1; reqW = 0; reqA = 12'h041; dV = 1; dT = 2'd0; dA = 10'h3FF;
    tick();
    check("R11 not served", 64'(doneNow), 64'd0);
    dV = 0;
    tick();
    check("R11 served next", 64'(doneNow), 64'd1);
    reqV = 0;

    // R4: invalidate of a shared copy
    clearSeen();
    dirMsg(2'd1, 10'h010, 64'h0);
    idle(2);
    dirMsg(2'd0, 10'h010, 64'h0);
    access(0, 12'h041, 16'h0, 0, 64'h0000_0000_0009_0000, 0);
    check("R4 read misses", 64'(seenT[1]), 64'd0);
    check("R4 refilled", 64'(lastRd), 64'h0009);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule